// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog that sits on a simple 32-bit register port with word-aligned addresses. A free-running timebase counter runs from power-on. Software can read it, for example to confirm that the clock is alive. While the watchdog is enabled, a separate interval counter measures windows of 2^N clock cycles, where N is a parameter.

Escalation has two steps. When the first window runs out, the block sets a pending flag and drives an interrupt. If software has not cleared that flag before the next window runs out, the block emits a system reset pulse of fixed length and latches a sticky "a watchdog reset happened" bit. The full timeout is therefore two windows.

Software services the watchdog by writing a one to the pending flag. This clears the flag and restarts the window. There are two enable bits, one in each control register. The watchdog runs while either of them is set, so stopping it takes two writes. An optional build-time lock makes the enables impossible to clear once either has been set.

Top module: `twostage_wdt`

## Requirements
- R1: Registers are decoded on address bits [3:2]; bits [1:0] are ignored. Word 0 (offset 0x0) reads bit 3 as the reset-happened flag, bit 2 as the pending flag and bit 1 as the first enable; its other bits read 0. Word 1 (offset 0x4) reads bit 0 as the second enable. Word 2 (offset 0x8) reads the timebase. Word 3 reads 0. All flags and enables are 0 after power-on reset.
- R2: The timebase is 0 after reset and increments by one on every clock edge, whether or not the watchdog is enabled. Two reads taken k cycles apart differ by k.
- R3: The watchdog runs while either enable is 1. The pending flag sets exactly 2^N clock edges after the edge that committed the enabling write.
- R4: The interrupt output is high while the pending flag is set, and rises only on a window expiry.
- R5: An expiry while the pending flag is set drives the reset output high for RST_PULSE cycles, starting with the next cycle, and sets the reset-happened flag. The pending flag stays set.
- R6: Writing word 0 with bit 2 = 1 clears the pending flag and restarts the window. Writing bit 2 = 0 does not restart the window.
- R7: Writing word 0 with bit 3 = 1 clears the reset-happened flag. Neither the reset pulse nor disabling the watchdog clears it.
- R8: When both enables are 0, the interval counter stops and the pending flag clears on the next edge. Either enable alone keeps the watchdog running.
- R9: With ENABLE_ONCE = 1, once either enable is set, writes of 0 to the enables have no effect, and the watchdog keeps running.
- R10: A servicing write that commits on the edge where a window would expire wins. No expiry is taken, and the next window is a full 2^N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timebase clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_wr | input | 1 | Write strobe, committed on the rising edge |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_irq | output | 1 | First-stage interrupt, level |
| wdt_reset | output | 1 | Second-stage system reset pulse, active high |

## Verification
The bound checker watches properties that hold on every cycle:
- the timebase steps by one;
- a first expiry sets the pending flag;
- every rising reset pulse is caused by a second expiry, and that expiry sets the sticky flag;
- stopping clears the pending flag;
- a servicing write beats a coincident expiry;
- the lock keeps the watchdog running.

Only the bench scenarios can show the absolute timing: expiry exactly 2^N edges after enabling, the exact pulse length, and that bit-2-zero writes leave the window untouched. Randomized service gaps shorter than a window also show that a well-behaved software loop never sees the interrupt.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;

  localparam int BIT_SEEN  = 3;
  localparam int BIT_STATE = 2;
  localparam int BIT_EN1   = 1;
  localparam int BIT_EN2   = 0;

  typedef enum logic [1:0] {
    SEL_CTRL0 = 2'd0,
    SEL_CTRL1 = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_NONE  = 2'd3
  } word_sel_e;

  function automatic word_sel_e decode_word(logic [ADDR_W-1:0] addr);
    word_sel_e s;
    case (addr[3:2])
      2'd0:    s = SEL_CTRL0;
      2'd1:    s = SEL_CTRL1;
      2'd2:    s = SEL_TBASE;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] read_word(word_sel_e s, logic seen, logic state,
                                                  logic en1, logic en2, logic [WORD_W-1:0] tb);
    logic [WORD_W-1:0] w;
    w = '0;
    case (s)
      SEL_CTRL0: begin
        w[BIT_SEEN]  = seen;
        w[BIT_STATE] = state;
        w[BIT_EN1]   = en1;
      end
      SEL_CTRL1: w[BIT_EN2] = en2;
      SEL_TBASE: w = tb;
      default:   w = '0;
    endcase
    return w;
  endfunction

  // Next value of an enable bit: a locked bit can only be set.
  function automatic logic next_enable(logic locked, logic cur, logic req);
    return locked ? (cur | req) : req;
  endfunction
endpackage

// File: rtl/twd_counters.sv
module twd_counters #(
  parameter int TB_W     = 32,
  parameter int IVL_LOG2 = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  output logic [TB_W-1:0] tb_cnt,
  output logic            expire
);
  logic [IVL_LOG2-1:0] ivl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ivl_q <= '0;
    else if (!run || restart) ivl_q <= '0;
    else                      ivl_q <= ivl_q + 1'b1;
  end

  assign expire = run && !restart && (ivl_q == '1);
endmodule

// File: rtl/twd_regs.sv
module twd_regs
  import twd_pkg::*;
#(
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              state_q,
  input  logic              seen_q,
  input  logic [WORD_W-1:0] tb_word,
  output logic              en1_q,
  output logic              en2_q,
  output logic              locked,
  output logic              ka_clr,
  output logic              seen_clr,
  output logic [WORD_W-1:0] bus_rdata
);
  word_sel_e sel;
  logic wr0, wr1;
  logic unused_bits;

  assign sel      = decode_word(bus_addr);
  assign wr0      = bus_wr && (sel == SEL_CTRL0);
  assign wr1      = bus_wr && (sel == SEL_CTRL1);
  assign ka_clr   = wr0 && bus_wdata[BIT_STATE];
  assign seen_clr = wr0 && bus_wdata[BIT_SEEN];

  generate
    if (ENABLE_ONCE) begin : g_lock
      assign locked = en1_q | en2_q;
    end else begin : g_free
      assign locked = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q <= 1'b0;
      en2_q <= 1'b0;
    end else begin
      if (wr0) en1_q <= next_enable(locked, en1_q, bus_wdata[BIT_EN1]);
      if (wr1) en2_q <= next_enable(locked, en2_q, bus_wdata[BIT_EN2]);
    end
  end

  assign bus_rdata   = read_word(sel, seen_q, state_q, en1_q, en2_q, tb_word);
  assign unused_bits = ^{bus_wdata[WORD_W-1:4], bus_addr[1:0]};
endmodule

// File: rtl/twd_stage.sv
module twd_stage #(
  parameter int RST_PULSE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic expire,
  input  logic ka_clr,
  input  logic seen_clr,
  output logic state_q,
  output logic seen_q,
  output logic fire,
  output logic reset_out
);
  localparam int PW = $clog2(RST_PULSE + 1);
  logic [PW-1:0] pulse_q;

  assign fire = expire && state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= 1'b0;
    else if (!run)   state_q <= 1'b0;
    else if (ka_clr) state_q <= 1'b0;
    else if (expire) state_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (fire)     seen_q <= 1'b1;
    else if (seen_clr) seen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pulse_q <= '0;
    else if (fire)          pulse_q <= PW'(RST_PULSE);
    else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
  end

  assign reset_out = (pulse_q != '0);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twd_pkg::*;
#(
  parameter int TB_W        = 32,
  parameter int IVL_LOG2    = 8,
  parameter int RST_PULSE   = 8,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_reset
);
  logic            en1_w, en2_w, run_w, locked_w;
  logic            ka_w, seen_clr_w, expire_w, fire_w;
  logic            state_w, seen_w;
  logic [TB_W-1:0] tb_cnt_w;
  logic [31:0]     tb_word_w;

  assign run_w = en1_w | en2_w;

  always_comb begin
    tb_word_w = '0;
    tb_word_w[TB_W-1:0] = tb_cnt_w;
  end

  twd_counters #(.TB_W(TB_W), .IVL_LOG2(IVL_LOG2)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .restart(ka_w),
    .tb_cnt(tb_cnt_w), .expire(expire_w)
  );

  twd_regs #(.ENABLE_ONCE(ENABLE_ONCE)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .state_q(state_w), .seen_q(seen_w),
    .tb_word(tb_word_w), .en1_q(en1_w), .en2_q(en2_w), .locked(locked_w),
    .ka_clr(ka_w), .seen_clr(seen_clr_w), .bus_rdata(bus_rdata)
  );

  twd_stage #(.RST_PULSE(RST_PULSE)) stage_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .expire(expire_w),
    .ka_clr(ka_w), .seen_clr(seen_clr_w), .state_q(state_w),
    .seen_q(seen_w), .fire(fire_w), .reset_out(wdt_reset)
  );

  assign wdt_irq = state_w;
endmodule

// File: rtl/twd_checks.sv
module twd_checks #(
  parameter int TB_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            expire,
  input logic            fire,
  input logic            ka_clr,
  input logic            state_q,
  input logic            seen_q,
  input logic            locked,
  input logic            wdt_irq,
  input logic            wdt_reset,
  input logic [TB_W-1:0] tb_cnt
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> tb_cnt == $past(tb_cnt) + 1'b1);

  // R3
  first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !state_q) |=> state_q);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(wdt_irq)) |-> $past(expire));

  // R5
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(wdt_reset)) |-> $past(fire));

  // R5
  seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (seen_q && wdt_reset && state_q));

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !state_q);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> run);

  // R10
  ka_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ka_clr |=> !state_q);
endmodule

bind twostage_wdt twd_checks #(.TB_W(TB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_w), .expire(expire_w), .fire(fire_w),
  .ka_clr(ka_w), .state_q(state_w), .seen_q(seen_w), .locked(locked_w),
  .wdt_irq(wdt_irq), .wdt_reset(wdt_reset), .tb_cnt(tb_cnt_w)
);

// File: tb/twostage_wdt_tb_top.sv
module twostage_wdt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 5;
  localparam int PULSE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_reset;

  logic        b2_wr = 1'b0;
  logic [3:0]  b2_addr = '0;
  logic [31:0] b2_wdata = '0;
  logic [31:0] b2_rdata;
  logic        irq2, rst2;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdt #(.TB_W(32), .IVL_LOG2(N), .RST_PULSE(PULSE), .ENABLE_ONCE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_reset(wdt_reset)
  );

  twostage_wdt #(.TB_W(32), .IVL_LOG2(N), .RST_PULSE(PULSE), .ENABLE_ONCE(1'b1)) once_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(b2_wr), .bus_addr(b2_addr),
    .bus_wdata(b2_wdata), .bus_rdata(b2_rdata), .wdt_irq(irq2), .wdt_reset(rst2)
  );

  function automatic int window();
    return 1 << N;
  endfunction

  function automatic logic [31:0] ctrl0(logic seen, logic pend, logic en);
    return {28'd0, seen, pend, en, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr2(logic [3:0] a, logic [31:0] d);
    b2_wr = 1'b1; b2_addr = a; b2_wdata = d;
    @(negedge clk);
    b2_wr = 1'b0; b2_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd2(logic [3:0] a, output logic [31:0] d);
    b2_addr = a; #1; d = b2_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v, v2;
    int gap;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and decode
    rd(4'h0, v); check("R1 ctrl0 reset", v, 32'h0);
    rd(4'h4, v); check("R1 ctrl1 reset", v, 32'h0);
    rd(4'hC, v); check("R1 unmapped word", v, 32'h0);
    check("R1 irq reset", wdt_irq, 0);
    check("R1 reset out idle", wdt_reset, 0);

    // R2 free-running timebase while disabled
    rd(4'h8, v); idle(7); rd(4'h9, v2);
    check("R2 timebase delta", v2 - v, 32'd7);

    // R3 first expiry with first enable only
    wr(4'h0, 32'h2);
    rd(4'h0, v); check("R1 en1 readback", v, ctrl0(0, 0, 1));
    idle(window() - 1);
    check("R3 no expiry before window", wdt_irq, 0);
    idle(1);
    check("R3 expiry at window", wdt_irq, 1);
    rd(4'h0, v); check("R4 pending flag readback", v, ctrl0(0, 1, 1));

    // R5 second expiry
    idle(window() - 1);
    check("R5 no reset before 2nd window", wdt_reset, 0);
    idle(1);
    check("R5 reset pulse starts", wdt_reset, 1);
    rd(4'h0, v); check("R5 seen flag set", v, ctrl0(1, 1, 1));
    idle(PULSE - 1);
    check("R5 reset pulse last cycle", wdt_reset, 1);
    idle(1);
    check("R5 reset pulse ended", wdt_reset, 0);
    rd(4'h0, v); check("R7 seen survives pulse", v[3], 1'b1);

    // R8 disable both: pending clears, seen stays (R7)
    wr(4'h0, 32'h0);
    idle(1);
    rd(4'h0, v); check("R8 stop clears pending, R7 seen kept", v, ctrl0(1, 0, 0));
    wr(4'h0, 32'h8);
    rd(4'h0, v); check("R7 seen cleared by write one", v, 32'h0);

    // R8 second enable alone keeps it running, then stop
    wr(4'h4, 32'h1);
    rd(4'h4, v); check("R1 en2 readback", v, 32'h1);
    idle(window());
    check("R8 en2 alone runs", wdt_irq, 1);
    wr(4'h4, 32'h0);
    idle(1);
    check("R8 stop clears irq", wdt_irq, 0);
    idle(2 * window() + 2);
    check("R8 counter stopped", wdt_irq, 0);
    check("R8 no reset when stopped", wdt_reset, 0);

    // R6 randomized service gaps shorter than a window
    wr(4'h0, 32'h2);
    for (int k = 0; k < 20; k++) begin
      gap = 1 + int'($urandom % (window() - 3));
      idle(gap);
      check("R6 serviced never pends", wdt_irq, 0);
      wr(4'h0, 32'h6);
    end
    // R6 write with bit 2 = 0 does not restart the window
    gap = 1 + int'($urandom % (window() / 2));
    idle(gap);
    wr(4'h0, 32'h2);
    idle(window() - gap - 2);
    check("R6 zero write: not yet expired", wdt_irq, 0);
    idle(1);
    check("R6 zero write did not restart", wdt_irq, 1);

    // R10 service committing on the expiry edge wins
    wr(4'h0, 32'h6);
    idle(window() - 1);
    wr(4'h0, 32'h6);
    check("R10 coincident service wins", wdt_irq, 0);
    idle(window() - 1);
    check("R10 full window after service", wdt_irq, 0);
    idle(1);
    check("R10 next expiry on time", wdt_irq, 1);
    check("R10 no reset", wdt_reset, 0);
    wr(4'h0, 32'h4);
    check("R6 clear pending", wdt_irq, 0);

    // R9 enable lock on the locked instance
    wr2(4'h0, 32'h2);
    wr2(4'h0, 32'h0);
    wr2(4'h4, 32'h0);
    rd2(4'h0, v); check("R9 en1 stays set", v[1], 1'b1);
    idle(window());
    check("R9 locked watchdog still runs", irq2, 1);
    wr(4'h0, 32'h0);
    idle(1);
    check("R9 unlocked instance can stop", wdt_irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule